// File: doc/BRIEF.md
# Pixel Bias Subtract and Packer

This block takes a stream of 8-bit samples from a scanning image source. Samples arrive one per clock while a capture-enable input is high. Most samples are pixels. At a fixed spacing, one sample carries a fresh bias byte instead of a pixel. The block keeps the most recent bias and subtracts it from every pixel. It then packs the corrected pixels, one to four at a time, into 32-bit words.

Each packed word goes out on a valid/ready handshake together with a word address that counts up through the frame. A single-cycle flag marks the moment the last word of a frame has been taken. Raising capture enable again starts a new frame.

The packing factor, the frame size, the bias spacing, the base address and the address ceiling are all parameters.

Top module: `pix_bias_packer`

## Requirements
- R1: A sample on `pix_in` is consumed at a rising `clk` edge only when `cap_en` and `pix_ready` are both high. Once 256 pixels of the current frame have been stored, `pix_ready` stays low until the next frame starts.
- R2: Within a frame, each run of 16 stored pixels is followed by one consumed sample that is not stored. That sample becomes the new bias instead.
- R3: Each stored pixel equals the sample minus the current bias, modulo 256, with no saturation. The bias is zero after reset.
- R4: Pixel k of a group goes into bits 8k+7:8k of the word, with k=0 being the earliest pixel. Bytes at or above the packing factor read zero.
- R5: A frame yields 256 / PACK words, rounded down. Any leftover pixel is dropped. Word i carries address BASE_ADDR + i, and every address stays below 350.
- R6: While `wd_valid` is high and `wd_ready` is low, the word and its address hold steady and `pix_ready` is low.
- R7: `frame_done` is high for exactly one cycle: the cycle right after the handshake of the frame's final word.
- R8: A rising `cap_en` restarts the pixel, group, bias-interval and word-address counters and discards any partial group. The bias value is kept.
- R9: While `rst` is high at a clock edge, the block clears the bias, all counters, the partial word and `wd_valid`, and holds `frame_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_en | input | 1 | Capture enable; a rising edge starts a frame |
| pix_in | input | 8 | Incoming sample (pixel or bias) |
| pix_ready | output | 1 | Sample will be consumed if `cap_en` is high |
| wd_valid | output | 1 | Packed word is available |
| wd_ready | input | 1 | Downstream takes the word |
| wd_data | output | 32 | Packed pixel word |
| wd_addr | output | 23 | Word address |
| frame_done | output | 1 | One-cycle pulse after the last word of a frame |

## Verification
The properties rely on two things about the environment. First, `wd_ready` may change on any cycle. Second, a frame is restarted only by taking `cap_en` low and then high again. Nothing assumes a sample is held on `pix_in` across a stall.

The bench drives every input away from the clock edge. It advances to the next sample only after seeing `pix_ready` together with `cap_en`. This keeps its model of the stream in step with what the block actually consumed, even under the irregular ready patterns it applies.

// File: rtl/pix_bias_packer.sv
module pix_bias_packer #(
  parameter int PACK       = 4,
  parameter int FRAME_W    = 16,
  parameter int FRAME_H    = 16,
  parameter int BIAS_GAP   = 16,
  parameter int ADDR_W     = 23,
  parameter int BASE_ADDR  = 0,
  parameter int ADDR_LIMIT = 350
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [7:0]        pix_in,
  output logic              pix_ready,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [31:0]       wd_data,
  output logic [ADDR_W-1:0] wd_addr,
  output logic              frame_done
);
  localparam int NPIX   = FRAME_W * FRAME_H;
  localparam int NWORDS = NPIX / PACK;
  localparam int PW     = $clog2(NPIX + 1);
  localparam int GW     = $clog2(BIAS_GAP + 1);
  localparam int LW     = (PACK > 1) ? $clog2(PACK) : 1;

  logic              cap_q;
  logic [7:0]        bias;
  logic [PW-1:0]     pix_cnt;
  logic [GW-1:0]     gap_cnt;
  logic [LW-1:0]     lane;
  logic [ADDR_W-1:0] idx;
  logic [31:0]       part;
  logic              out_last;

  wire start = cap_en && !cap_q;

  wire [PW-1:0]     pix_eff  = start ? '0 : pix_cnt;
  wire [GW-1:0]     gap_eff  = start ? '0 : gap_cnt;
  wire [LW-1:0]     lane_eff = start ? '0 : lane;
  wire [ADDR_W-1:0] idx_eff  = start ? '0 : idx;
  wire [31:0]       part_eff = start ? '0 : part;

  wire room      = pix_eff < PW'(NPIX);
  wire slot_free = !wd_valid || wd_ready;
  wire hs        = wd_valid && wd_ready;

  assign pix_ready = room && slot_free;

  wire        take       = cap_en && pix_ready;
  wire        is_bias    = gap_eff == GW'(BIAS_GAP);
  wire [7:0]  adj        = pix_in - bias;
  wire [31:0] merged     = part_eff | (32'(adj) << {lane_eff, 3'b000});
  wire        group_full = lane_eff == LW'(PACK - 1);
  wire        in_words   = pix_eff < PW'(NWORDS * PACK);
  wire        emit       = take && !is_bias && group_full && in_words;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q      <= 1'b0;
      bias       <= '0;
      pix_cnt    <= '0;
      gap_cnt    <= '0;
      lane       <= '0;
      idx        <= '0;
      part       <= '0;
      wd_valid   <= 1'b0;
      wd_data    <= '0;
      wd_addr    <= '0;
      out_last   <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      cap_q      <= cap_en;
      frame_done <= hs && out_last;
      pix_cnt    <= pix_eff;
      gap_cnt    <= gap_eff;
      lane       <= lane_eff;
      idx        <= idx_eff;
      part       <= part_eff;
      if (take) begin
        if (is_bias) begin
          bias    <= pix_in;
          gap_cnt <= '0;
        end else begin
          pix_cnt <= pix_eff + PW'(1);
          gap_cnt <= gap_eff + GW'(1);
          if (group_full) begin
            lane <= '0;
            part <= '0;
            if (in_words) idx <= idx_eff + ADDR_W'(1);
          end else begin
            lane <= lane_eff + LW'(1);
            part <= merged;
          end
        end
      end
      if (emit) begin
        wd_valid <= 1'b1;
        wd_data  <= merged;
        wd_addr  <= ADDR_W'(BASE_ADDR) + idx_eff;
        out_last <= idx_eff == ADDR_W'(NWORDS - 1);
      end else if (hs) begin
        wd_valid <= 1'b0;
      end
    end
  end

  a_r6_hold_word: assert property (@(posedge clk) disable iff (rst)
    wd_valid && !wd_ready |=> wd_valid && $stable(wd_data) && $stable(wd_addr));

  a_r6_stall_input: assert property (@(posedge clk) disable iff (rst)
    wd_valid && !wd_ready |-> !pix_ready);

  a_r5_addr_limit: assert property (@(posedge clk) disable iff (rst)
    wd_valid |-> wd_addr < ADDR_W'(ADDR_LIMIT));

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  a_r7_done_after_hs: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(wd_valid && wd_ready));

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wd_valid && !frame_done);

  generate
    if (PACK < 4) begin : g_zero_upper
      a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        wd_valid |-> wd_data[31:8*PACK] == '0);
    end
  endgenerate
endmodule

// File: tb/pix_bias_packer_test.sv
module pix_bias_packer_test;
  localparam int NS   = 271;
  localparam int NW4  = 64;
  localparam int NW2  = 128;
  localparam int NFR  = 4;
  localparam logic [23:0] FRAMES [NFR] = '{
    {8'd3,   8'd1,   8'd0},
    {8'd200, 8'd7,   8'd3},
    {8'd255, 8'd255, 8'd2},
    {8'd17,  8'd37,  8'd5}
  };

  logic clk = 0, rst = 1, cap_en = 0, wd_ready = 1, p2_on = 0, mon_on = 0;
  logic [7:0] pix_in = 0;
  logic pix_ready, wd_valid, frame_done;
  logic [31:0] wd_data;
  logic [22:0] wd_addr;
  logic p2_rdy, v2, fd2;
  logic [31:0] d2;
  logic [22:0] a2;

  always #5 clk = ~clk;

  pix_bias_packer uut (.clk(clk), .rst(rst), .cap_en(cap_en), .pix_in(pix_in),
    .pix_ready(pix_ready), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .wd_addr(wd_addr), .frame_done(frame_done));

  pix_bias_packer #(.PACK(2)) uut_p2 (.clk(clk), .rst(rst), .cap_en(cap_en && p2_on),
    .pix_in(pix_in), .pix_ready(p2_rdy), .wd_valid(v2), .wd_ready(1'b1),
    .wd_data(d2), .wd_addr(a2), .frame_done(fd2));

  int checks = 0, fails = 0, cyc = 0;
  int wi = 0, wi2 = 0, done_n = 0, done2_n = 0, done_cyc = -1, last_hs = -9;
  logic [31:0] exp4 [NW4];
  logic [31:0] exp2 [NW2];
  logic [7:0] mb = 0;
  logic acc;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic [7:0] v, input logic r);
    @(negedge clk);
    cap_en = c; pix_in = v; wd_ready = r;
    #3;
    acc = c && pix_ready;
  endtask

  task automatic build(input logic [7:0] seed, input logic [7:0] step);
    int gap = 0, p = 0;
    for (int i = 0; i < NW4; i++) exp4[i] = '0;
    for (int i = 0; i < NW2; i++) exp2[i] = '0;
    for (int i = 0; i < NS; i++) begin
      logic [7:0] s, d;
      s = seed + step * 8'(i);
      if (gap == 16) begin
        mb = s; gap = 0;
      end else begin
        d = s - mb;
        exp4[p/4][8*(p%4) +: 8] = d;
        exp2[p/2][8*(p%2) +: 8] = d;
        p++; gap++;
      end
    end
  endtask

  always begin
    @(negedge clk); #3;
    cyc++;
    if (mon_on && !rst) begin
      if (wd_valid && wd_ready) begin
        if (wi < NW4) begin
          chk($sformatf("R3/R4 word %0d data", wi), wd_data, exp4[wi]);
          chk($sformatf("R5 word %0d addr", wi), 32'(wd_addr), 32'(wi));
        end
        if (wi == NW4 - 1) last_hs = cyc;
        wi++;
      end
      if (frame_done) begin done_n++; done_cyc = cyc; end
      if (p2_on) begin
        if (v2) begin
          if (wi2 < NW2) begin
            chk($sformatf("R2/R4 p2 word %0d", wi2), d2, exp2[wi2]);
            chk($sformatf("R5 p2 addr %0d", wi2), 32'(a2), 32'(wi2));
          end
          wi2++;
        end
        if (fd2) done2_n++;
      end
    end
  end

  task automatic run_frame(input logic [7:0] seed, input logic [7:0] step, input int per);
    int i = 0;
    build(seed, step);
    wi = 0; wi2 = 0; done_n = 0; done2_n = 0;
    mon_on = 1;
    while (i < NS) begin
      drive(1, seed + step * 8'(i), (per == 0) || (cyc % per != 0));
      if (acc) i++;
    end
    drive(1, 8'hAA, 1);
    chk("R1 no intake after 256 pixels", 32'(pix_ready), 0);
    for (int k = 0; k < 6; k++) drive(0, 0, 1);
    chk("R5 word count", 32'(wi), NW4);
    chk("R7 one done pulse", 32'(done_n), 1);
    chk("R7 done timing", 32'(done_cyc), 32'(last_hs + 1));
    if (p2_on) begin
      chk("R5 p2 word count", 32'(wi2), NW2);
      chk("R7 p2 done pulse", 32'(done2_n), 1);
    end
    mon_on = 0;
  endtask

  initial begin
    logic [31:0] w;
    logic [7:0] a, b, c, d;
    drive(0, 0, 1); drive(0, 0, 1);
    chk("R9 reset valid", 32'(wd_valid), 0);
    chk("R9 reset done", 32'(frame_done), 0);
    @(negedge clk); rst = 0;

    for (int f = 0; f < NFR; f++) begin
      p2_on = (f == 0);
      run_frame(FRAMES[f][23:16], FRAMES[f][15:8], int'(FRAMES[f][7:0]));
    end
    p2_on = 0;

    for (int k = 0; k < 3; k++) drive(1, 8'h50 + 8'(k), 1);
    drive(0, 0, 1); drive(0, 0, 1);
    chk("R8 partial group not emitted", 32'(wd_valid), 0);
    a = 8'h10; b = 8'h81; c = 8'hF0; d = 8'h07;
    drive(1, a, 0); drive(1, b, 0); drive(1, c, 0); drive(1, d, 0);
    drive(1, 8'h99, 0);
    w = {d - mb, c - mb, b - mb, a - mb};
    chk("R8 restart valid", 32'(wd_valid), 1);
    chk("R8 restart word", wd_data, w);
    chk("R8 restart addr", 32'(wd_addr), 0);
    chk("R6 stall intake", 32'(pix_ready), 0);
    drive(1, 8'h98, 0); drive(1, 8'h97, 0);
    chk("R6 word held", wd_data, w);
    chk("R6 valid held", 32'(wd_valid), 1);
    drive(1, 8'h55, 1);
    chk("R6 intake resumes", 32'(pix_ready), 1);

    @(negedge clk); rst = 1; cap_en = 0; wd_ready = 0;
    @(negedge clk); #3;
    chk("R9 reset clears valid", 32'(wd_valid), 0);
    rst = 0;
    drive(0, 0, 1);
    drive(1, 8'h21, 1); drive(1, 8'h43, 1); drive(1, 8'h65, 1); drive(1, 8'h87, 1);
    drive(1, 0, 1);
    chk("R3 bias zero after reset", wd_data, 32'h87654321);
    chk("R5 addr after reset", 32'(wd_addr), 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule